// File: doc/BRIEF.md
# PLL Output Divider Bank

The block produces a set of integer-divided clocks from the VCO clock of a PLL. Each output divider holds a programmed ratio and an enable bit. Its output toggles only while the enable bit is set and the PLL reports lock. A small control register powers the PLL up or down. A status register reports lock, which a behavioural delay model produces. The model asserts lock a fixed number of VCO cycles after power-up and drops it at once on power-down.

Software drives the block through a flat word-addressed register port. Writes take effect on the clock edge. Reads are combinational from the address. The expected sequence is as follows. Disable every divider, power the PLL down, program the dividers, power up, then poll lock. To change the ratio of a running divider, clear its enable bit, write the new ratio, and set the enable bit again.

Top module: `pll_odiv_bank`

## Requirements
- R1: After reset the PLL is powered down, lock reads 0, every divider is disabled with a ratio field of 0, and all divided outputs are low.
- R2: The register map uses these word addresses and bit positions:
  - Address 0 is the control register, with power-down at bit 0 (1 means powered down).
  - Address 1 is the status register, with lock at bit 0.
  - Address 2+k is divider k, holding the ratio field N-1 in bits [DIV_W-1:0] and the enable bit at bit 31.
  - Every read returns the stored values, with all other bits reading 0.
- R3: After a write of 0 to the control register, lock reads 1 exactly LOCK_CYC clock cycles after the write edge.
- R4: A write of 1 to the control register makes lock read 0 and holds every output low from the write edge onward.
- R5: While lock is 0, every divided output stays low.
- R6: While a divider's enable bit is clear, its output is low. Clearing the bit forces the output low from that write edge.
- R7: A running divider with field value F gives a period of N=F+1 cycles. The output is high for ceil(N/2) cycles and low for floor(N/2) cycles. The first high cycle begins one cycle after the divider starts running, which needs enable set and lock high. A field of 0 holds the output high while running.
- R8: A write to a divider whose enable bit is already set updates only the enable bit. The ratio field and the running ratio are kept.
- R9: Writes to the status register and to addresses above the last divider have no effect, and reads of those unused addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | VCO clock that all dividers count |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| lock_o | output | 1 | PLL lock indication |
| div_clk_o | output | N_DIV | Gated divided outputs, one per divider |

## Verification
The assertions assume the following about the inputs: reset is applied at time zero, and the write strobe, address and data change only away from the active clock edge. They also take the ratio field to be frozen whenever the enable bit was set in the previous cycle. The bench drives every input at the falling edge and checks at the next falling edge against a cycle model built from the requirements. Random writes are drawn with small ratio fields and rare power-down toggles, so that lock is regained and many full output periods are observed. These writes include deliberate writes to running dividers, to the status register and to an unused address.

// File: rtl/pll_odiv_pkg.sv
package pll_odiv_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned EN_BIT   = DATA_W - 1;
  localparam int unsigned CTRL_ADR = 0;
  localparam int unsigned STAT_ADR = 1;
  localparam int unsigned DIV_BASE = 2;
endpackage

// File: rtl/pll_lock_model.sv
module pll_lock_model #(
  parameter int unsigned LOCK_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_i,
  output logic lock_o
);
  localparam int unsigned CW = $clog2(LOCK_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          lk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lk_q  <= 1'b0;
    end else if (pd_i) begin
      cnt_q <= '0;
      lk_q  <= 1'b0;
    end else if (!lk_q) begin
      if (cnt_q == CW'(LOCK_CYC - 1)) lk_q <= 1'b1;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // power-down removes lock without waiting for the counter
  assign lock_o = lk_q & ~pd_i;
endmodule

// File: rtl/pll_odiv.sv
module pll_odiv #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [DIV_W-1:0] wdiv_i,
  input  logic             wen_i,
  input  logic             lock_i,
  output logic             en_o,
  output logic [DIV_W-1:0] div_o,
  output logic             clk_o
);
  logic             en_q, ph_q, run;
  logic [DIV_W-1:0] div_q, cnt_q, hi_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      div_q <= '0;
    end else if (wr_i) begin
      en_q <= wen_i;
      if (!en_q) div_q <= wdiv_i;  // ratio frozen while enabled
    end
  end

  assign run    = en_q & lock_i;
  assign hi_len = (div_q >> 1) + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= (cnt_q == div_q) ? '0 : cnt_q + 1'b1;
      ph_q  <= (cnt_q < hi_len);
    end
  end

  assign en_o  = en_q;
  assign div_o = div_q;
  assign clk_o = ph_q & run;
endmodule

// File: rtl/pll_odiv_bank.sv
module pll_odiv_bank
  import pll_odiv_pkg::*;
#(
  parameter int unsigned N_DIV    = 4,
  parameter int unsigned DIV_W    = 8,
  parameter int unsigned LOCK_CYC = 16,
  localparam int unsigned ADDR_W  = $clog2(N_DIV + DIV_BASE)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              lock_o,
  output logic [N_DIV-1:0]  div_clk_o
);
  logic                        pd_q;
  logic                        lock;
  logic [N_DIV-1:0]            en_vec;
  logic [N_DIV-1:0][DIV_W-1:0] div_vec;
  logic                        unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   pd_q <= 1'b1;
    else if (we_i && addr_i == ADDR_W'(CTRL_ADR))  pd_q <= wdata_i[0];
  end

  pll_lock_model #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pd_i   (pd_q),
    .lock_o (lock)
  );

  for (genvar k = 0; k < N_DIV; k++) begin : g_div
    pll_odiv #(.DIV_W(DIV_W)) u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (we_i && addr_i == ADDR_W'(DIV_BASE + k)),
      .wdiv_i (wdata_i[DIV_W-1:0]),
      .wen_i  (wdata_i[EN_BIT]),
      .lock_i (lock),
      .en_o   (en_vec[k]),
      .div_o  (div_vec[k]),
      .clk_o  (div_clk_o[k])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(CTRL_ADR)) rdata_o[0] = pd_q;
    if (addr_i == ADDR_W'(STAT_ADR)) rdata_o[0] = lock;
    for (int k = 0; k < N_DIV; k++) begin
      if (addr_i == ADDR_W'(DIV_BASE + k)) begin
        rdata_o[DIV_W-1:0] = div_vec[k];
        rdata_o[EN_BIT]    = en_vec[k];
      end
    end
  end

  assign lock_o = lock;
endmodule

// File: rtl/pll_odiv_bank_chk.sv
module pll_odiv_bank_chk #(
  parameter int unsigned N_DIV = 4,
  parameter int unsigned DIV_W = 8
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        pd_i,
  input logic                        lock_i,
  input logic [N_DIV-1:0]            en_i,
  input logic [N_DIV-1:0][DIV_W-1:0] div_i,
  input logic [N_DIV-1:0]            div_clk_i
);
  p_lock_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_i) |-> (!pd_i && $past(!pd_i)));

  p_pd_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pd_i) |-> (div_clk_i == '0));

  p_unlocked_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_i |-> (div_clk_i == '0));

  for (genvar k = 0; k < N_DIV; k++) begin : g_chk
    p_disabled_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i[k] |-> !div_clk_i[k]);

    p_div_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(en_i[k]) |-> (div_i[k] == $past(div_i[k])));
  end
endmodule

bind pll_odiv_bank pll_odiv_bank_chk #(.N_DIV(N_DIV), .DIV_W(DIV_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pd_i      (pd_q),
  .lock_i    (lock),
  .en_i      (en_vec),
  .div_i     (div_vec),
  .div_clk_i (div_clk_o)
);

// File: tb/pll_odiv_bank_test.sv
module pll_odiv_bank_test;
  localparam int ND = 4;
  localparam int DW = 8;
  localparam int LC = 16;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          lock;
  logic [ND-1:0] dclk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int m_pd = 1, m_up = 0;
  int m_en[ND], m_div[ND], m_t[ND], m_o[ND];

  always #2.5 clk = ~clk;

  pll_odiv_bank #(.N_DIV(ND), .DIV_W(DW), .LOCK_CYC(LC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .lock_o(lock), .div_clk_o(dclk)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int mlock();
    return (m_pd == 0 && m_up >= LC) ? 1 : 0;
  endfunction

  function automatic logic [31:0] mread(int a);
    logic [31:0] v = '0;
    if (a == 0) v[0] = m_pd[0];
    else if (a == 1) v[0] = mlock() != 0;
    else if (a >= 2 && a < 2 + ND) begin
      v[DW-1:0] = m_div[a-2][DW-1:0];
      v[31] = m_en[a-2] != 0;
    end
    return v;
  endfunction

  function automatic logic [ND-1:0] mclk();
    logic [ND-1:0] v;
    for (int k = 0; k < ND; k++) v[k] = (m_o[k] != 0) && (m_en[k] != 0) && (mlock() != 0);
    return v;
  endfunction

  // called at a falling edge; returns at the next falling edge after checking
  task automatic step(bit w, int a, logic [31:0] d);
    int lk;
    we = w; addr = AW'(a); wdata = d;
    @(posedge clk);
    lk = mlock();
    for (int k = 0; k < ND; k++) begin
      int n, h;
      n = m_div[k] + 1;
      h = (n + 1) / 2;
      if (m_en[k] != 0 && lk != 0) begin
        m_o[k] = ((m_t[k] % n) < h) ? 1 : 0;
        m_t[k]++;
      end else begin
        m_o[k] = 0;
        m_t[k] = 0;
      end
    end
    if (m_pd != 0) m_up = 0;
    else if (m_up < LC) m_up++;
    if (w) begin
      if (a == 0) m_pd = int'(d[0]);
      else if (a >= 2 && a < 2 + ND) begin
        if (m_en[a-2] == 0) m_div[a-2] = int'(d[DW-1:0]);
        m_en[a-2] = int'(d[31]);
      end
    end
    @(negedge clk);
    check(mlock() != 0 ? "R7 divided outputs" : "R5 outputs while unlocked",
          32'(dclk), 32'(mclk()));
    check("R2 read data", rdata, mread(a));
  endtask

  task automatic idle(int n, int a);
    for (int i = 0; i < n; i++) step(0, a, '0);
  endtask

  function automatic logic [31:0] dv(bit en, int f);
    logic [31:0] v = '0;
    v[31] = en;
    v[DW-1:0] = DW'(f);
    return v;
  endfunction

  initial begin
    for (int k = 0; k < ND; k++) begin m_en[k] = 0; m_div[k] = 0; m_t[k] = 0; m_o[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 outputs low", 32'(dclk), 32'd0);
    check("R1 lock low", 32'(lock), 32'd0);
    for (int a = 0; a < 2 + ND; a++) begin
      step(0, a, '0);
      check("R1 register reset value", rdata, (a == 0) ? 32'd1 : 32'd0);
    end
    // program while powered down: N=2,3,1,8
    step(1, 2, dv(1, 1));
    step(1, 3, dv(1, 2));
    step(1, 4, dv(1, 0));
    step(1, 5, dv(1, 7));
    idle(4, 1);
    // R3 power up and time lock
    step(1, 0, 32'd0);
    begin
      int cyc = 0;
      while (rdata[0] !== 1'b1 && cyc < 4 * LC) begin step(0, 1, '0); cyc++; end
      check("R3 lock delay in cycles", 32'(cyc), 32'(LC));
    end
    idle(40, 2);
    // R8 write to running divider keeps ratio
    step(1, 2, dv(1, 5));
    check("R8 ratio kept while enabled", {24'd0, rdata[7:0]}, 32'd1);
    idle(20, 2);
    // R6 disable gates output at once
    idle(1, 3);
    while (dclk[1] !== 1'b1) idle(1, 3);
    step(1, 3, dv(0, 2));
    check("R6 output low after disable", 32'(dclk[1]), 32'd0);
    step(1, 3, dv(0, 4));
    step(1, 3, dv(1, 4));
    idle(30, 3);
    // R9 ignored writes
    step(1, 1, 32'd0);
    check("R9 status write ignored", rdata, 32'd1);
    step(1, 2 + ND, 32'hffff_ffff);
    check("R9 unused address reads zero", rdata, 32'd0);
    idle(5, 2);
    // R4 power-down
    step(1, 0, 32'd1);
    check("R4 lock drops on power-down", 32'(lock), 32'd0);
    check("R4 outputs low on power-down", 32'(dclk), 32'd0);
    idle(5, 1);
    step(1, 0, 32'd0);
    idle(LC + 10, 1);
    // random mix
    void'($urandom(32'd4711));
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 55) step(0, $urandom_range(0, 2 + ND), '0);
      else if (r < 95) step(1, $urandom_range(2, 1 + ND),
                            dv(1'($urandom_range(0, 1)), $urandom_range(0, 12)));
      else if (r < 97) step(1, 0, 32'($urandom_range(0, 1)));
      else step(1, $urandom_range(1, 2) == 1 ? 1 : 2 + ND, $urandom);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule